// File: doc/BRIEF.md
# Steered Replicated-Register Access Sequencer

This block performs a single steered access to a replicated register on behalf of one requester. A replicated register has many copies behind a single bus address. A steering selector register decides which copy a unicast access reaches, and a multicast bit in that selector lets one write update every copy. The requester supplies an operation, a target address, a group and an instance number, write data and a clear mask. The sequencer then drives a simple single-outstanding register bus through a fixed series of transactions. In the newer selector mode, it first takes a shared hardware semaphore. It then steers the selector, performs the target access, puts the selector back as the mode requires, releases the semaphore, and returns the read value and a timeout flag.

Two selector conventions are supported, and `legacyMode` picks one per request. In the newer convention, the selector is written outright and never read, and a polled semaphore guards the sequence. In the legacy convention, the selector is read, modified in its steering fields only, and restored afterwards, and the semaphore is not used. Four operations are available: steered read, unicast write, multicast write, and multicast read-modify-write.

Top module: `steer_seq`

## Requirements
- R1: After reset, `busy`, `done` and `busValid` are 0. A request (`reqValid` high) is accepted only while `busy` is 0. A request raised while busy issues no bus traffic and starts no second sequence.
- R2: Every bus transaction holds `busValid`, `busWrite`, `busAddr` and `busWdata` stable until a cycle with `busReady` high, and the sequence does not advance before then.
- R3: In new mode, the first transactions are reads of `SEM_ADDR`, repeated until one returns exactly 1. No other address is touched before that read, unless the timeout of R4 expires first.
- R4: If no semaphore read returns 1 within `POLL_LIMIT` cycles of polling, the sequence continues anyway and `rspTimeout` reads 1 at `done`. When the bus answers each poll in one cycle, exactly `POLL_LIMIT` polls are made. `rspTimeout` is 0 after a granted acquire.
- R5: New-mode steered read (`reqOp`=0): the selector is written with group in bits [11:8], instance in bits [3:0] and the multicast bit 16 set. The target is then read and the selector is not rewritten. `rspData` returns the value read.
- R6: New-mode unicast write (`reqOp`=1): the selector is written with the steering fields and bit 16 clear, then the target is written with `reqWdata`. After that the selector is written to 0x0001_0000.
- R7: Every new-mode sequence ends with a write of 1 to `SEM_ADDR` just before `done`. A legacy-mode sequence never addresses `SEM_ADDR`.
- R8: Legacy mode, read or unicast write: the selector is read first. It is rewritten with bits [11:8] and [3:0] replaced by group and instance, and bit 16 is cleared for a write and left unchanged for a read. After the target access, the original value is written back.
- R9: Multicast write (`reqOp`=2): in new mode, the selector is written to 0x0001_0000 and then the target is written. In legacy mode, the only transaction is the target write.
- R10: Read-modify-write (`reqOp`=3): a steered read of the target, done as in R5 or R8, is followed by a multicast write, done as in R9, of (old AND NOT `reqClear`) OR `reqWdata`. `rspData` returns the old value.
- R11: `done` is high for exactly one cycle and `busy` is high in that cycle. `busy` rises the cycle after acceptance and falls the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legacyMode | input | 1 | Selects the legacy selector convention for the request being accepted |
| reqValid | input | 1 | Request strobe, taken while idle |
| reqOp | input | 2 | 0 read, 1 unicast write, 2 multicast write, 3 read-modify-write |
| reqAddr | input | ADDR_W | Target register address |
| reqGroup | input | GRP_W | Steering group |
| reqInst | input | INST_W | Steering instance |
| reqWdata | input | DATA_W | Write data, or set mask for read-modify-write |
| reqClear | input | DATA_W | Clear mask for read-modify-write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rspData | output | DATA_W | Value read (0 for pure writes) |
| rspTimeout | output | 1 | Semaphore acquire timed out |
| busValid | output | 1 | Bus transaction request |
| busWrite | output | 1 | Bus direction, 1 for write |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busReady | input | 1 | Bus completes the current transaction |
| busRdata | input | DATA_W | Bus read data, valid with busReady |

## Verification
The hardest case to reach from the ports is a semaphore that is never granted. It depends entirely on what the bus returns, so the bench's bus responder can be told to answer every semaphore read with 0. The bench then counts the polls before the sequence moves on without ownership and checks that the release write still happens. The legacy paths are also hard to reach, because a partly modified selector is visible only as bus write data. The responder therefore models the selector register with a distinctive preset value, so that each field replacement, each multicast-bit decision and the final restore appear as exact words in the transaction log.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_UWRITE  = 2'd1,
    OP_MCWRITE = 2'd2,
    OP_RMW     = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACQ,
    S_SELRD,
    S_SELWR,
    S_ACC,
    S_RESTORE,
    S_MCSEL,
    S_MCACC,
    S_REL,
    S_DONE
  } state_e;

  // bus address source
  typedef enum logic [1:0] {
    A_SEM,
    A_SEL,
    A_TGT
  } asel_e;

  // bus write-data source
  typedef enum logic [2:0] {
    D_SEMFREE,
    D_STEER,
    D_RESTORE,
    D_MCONLY,
    D_TGTDATA,
    D_MCDATA
  } wsel_e;

  typedef struct packed {
    logic  capReq;
    logic  capOld;
    logic  capRd;
    logic  setTmo;
    asel_e addrSel;
    wsel_e dataSel;
  } strobe_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int POLL_LIMIT = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  op_e     reqOp,
  input  logic    legacyIn,
  input  op_e     curOp,
  input  logic    curLegacy,
  input  logic    busReady,
  input  logic    semGranted,
  output logic    busValid,
  output logic    busWrite,
  output logic    busy,
  output logic    done,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(POLL_LIMIT);

  state_e state, nextState;
  logic [CNT_W-1:0] pollCnt;

  // first state once ownership is settled
  function automatic state_e firstStep(op_e op, logic leg);
    if (op == OP_MCWRITE) return leg ? S_MCACC : S_MCSEL;
    return leg ? S_SELRD : S_SELWR;
  endfunction

  always_comb begin
    nextState   = state;
    stb         = '0;
    stb.addrSel = A_TGT;
    stb.dataSel = D_TGTDATA;
    busValid    = 1'b0;
    busWrite    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = legacyIn ? firstStep(reqOp, 1'b1) : S_ACQ;
        end
      end
      S_ACQ: begin
        busValid    = 1'b1;
        stb.addrSel = A_SEM;
        if (busReady) begin
          if (semGranted) begin
            nextState = firstStep(curOp, curLegacy);
          end else if (pollCnt >= CNT_LAST) begin
            stb.setTmo = 1'b1;
            nextState  = firstStep(curOp, curLegacy);
          end
        end
      end
      S_SELRD: begin
        busValid    = 1'b1;
        stb.addrSel = A_SEL;
        if (busReady) begin
          stb.capOld = 1'b1;
          nextState  = S_SELWR;
        end
      end
      S_SELWR: begin
        busValid    = 1'b1;
        busWrite    = 1'b1;
        stb.addrSel = A_SEL;
        stb.dataSel = D_STEER;
        if (busReady) nextState = S_ACC;
      end
      S_ACC: begin
        busValid = 1'b1;
        busWrite = (curOp == OP_UWRITE);
        if (busReady) begin
          stb.capRd = (curOp != OP_UWRITE);
          if (curLegacy || curOp == OP_UWRITE) nextState = S_RESTORE;
          else if (curOp == OP_RMW)            nextState = S_MCSEL;
          else                                 nextState = S_REL;
        end
      end
      S_RESTORE: begin
        busValid    = 1'b1;
        busWrite    = 1'b1;
        stb.addrSel = A_SEL;
        stb.dataSel = D_RESTORE;
        if (busReady) begin
          if (curOp == OP_RMW) nextState = curLegacy ? S_MCACC : S_MCSEL;
          else                 nextState = curLegacy ? S_DONE : S_REL;
        end
      end
      S_MCSEL: begin
        busValid    = 1'b1;
        busWrite    = 1'b1;
        stb.addrSel = A_SEL;
        stb.dataSel = D_MCONLY;
        if (busReady) nextState = S_MCACC;
      end
      S_MCACC: begin
        busValid    = 1'b1;
        busWrite    = 1'b1;
        stb.dataSel = D_MCDATA;
        if (busReady) nextState = curLegacy ? S_DONE : S_REL;
      end
      S_REL: begin
        busValid    = 1'b1;
        busWrite    = 1'b1;
        stb.addrSel = A_SEM;
        stb.dataSel = D_SEMFREE;
        if (busReady) nextState = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollCnt <= '0;
    end else begin
      state <= nextState;
      if (stb.capReq)                               pollCnt <= '0;
      else if (state == S_ACQ && pollCnt != CNT_MAX) pollCnt <= pollCnt + CNT_W'(1);
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int GRP_W    = 4,
  parameter int INST_W   = 4,
  parameter int GRP_LSB  = 8,
  parameter int INST_LSB = 0,
  parameter int MC_BIT   = 16,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h0FD0,
  parameter logic [ADDR_W-1:0] SEM_ADDR = 16'h0FD4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  op_e               reqOp,
  input  logic              legacyIn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [GRP_W-1:0]  reqGroup,
  input  logic [INST_W-1:0] reqInst,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqClear,
  input  logic [DATA_W-1:0] busRdata,
  output op_e               curOp,
  output logic              curLegacy,
  output logic              semGranted,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspTimeout
);

  localparam logic [DATA_W-1:0] GRP_MASK  = ((DATA_W'(1) << GRP_W) - DATA_W'(1)) << GRP_LSB;
  localparam logic [DATA_W-1:0] INST_MASK = ((DATA_W'(1) << INST_W) - DATA_W'(1)) << INST_LSB;
  localparam logic [DATA_W-1:0] MC_MASK   = DATA_W'(1) << MC_BIT;

  logic [ADDR_W-1:0] tgtAddr;
  logic [GRP_W-1:0]  grp;
  logic [INST_W-1:0] inst;
  logic [DATA_W-1:0] wdata, clrMask, oldSel;
  logic [DATA_W-1:0] steerFields, newSteer, legSteer, mcData;
  logic              isWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOp      <= OP_READ;
      curLegacy  <= 1'b0;
      tgtAddr    <= '0;
      grp        <= '0;
      inst       <= '0;
      wdata      <= '0;
      clrMask    <= '0;
      oldSel     <= '0;
      rspData    <= '0;
      rspTimeout <= 1'b0;
    end else begin
      if (stb.capReq) begin
        curOp      <= reqOp;
        curLegacy  <= legacyIn;
        tgtAddr    <= reqAddr;
        grp        <= reqGroup;
        inst       <= reqInst;
        wdata      <= reqWdata;
        clrMask    <= reqClear;
        rspData    <= '0;
        rspTimeout <= 1'b0;
      end
      if (stb.capOld) oldSel     <= busRdata;
      if (stb.capRd)  rspData    <= busRdata;
      if (stb.setTmo) rspTimeout <= 1'b1;
    end
  end

  assign isWr        = (curOp == OP_UWRITE);
  assign steerFields = (DATA_W'(grp) << GRP_LSB) | (DATA_W'(inst) << INST_LSB);
  assign newSteer    = steerFields | (isWr ? '0 : MC_MASK);
  assign legSteer    = (oldSel & ~(GRP_MASK | INST_MASK | (isWr ? MC_MASK : '0))) | steerFields;
  assign mcData      = (curOp == OP_RMW) ? ((rspData & ~clrMask) | wdata) : wdata;
  assign semGranted  = (busRdata == DATA_W'(1));

  always_comb begin
    unique case (stb.addrSel)
      A_SEM:   busAddr = SEM_ADDR;
      A_SEL:   busAddr = SEL_ADDR;
      default: busAddr = tgtAddr;
    endcase
  end

  always_comb begin
    unique case (stb.dataSel)
      D_SEMFREE: busWdata = DATA_W'(1);
      D_STEER:   busWdata = curLegacy ? legSteer : newSteer;
      D_RESTORE: busWdata = curLegacy ? oldSel : MC_MASK;
      D_MCONLY:  busWdata = MC_MASK;
      D_MCDATA:  busWdata = mcData;
      default:   busWdata = wdata;
    endcase
  end

endmodule

// File: rtl/steer_seq.sv
module steer_seq
  import steer_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int GRP_W      = 4,
  parameter int INST_W     = 4,
  parameter int GRP_LSB    = 8,
  parameter int INST_LSB   = 0,
  parameter int MC_BIT     = 16,
  parameter int POLL_LIMIT = 16,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h0FD0,
  parameter logic [ADDR_W-1:0] SEM_ADDR = 16'h0FD4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              legacyMode,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [GRP_W-1:0]  reqGroup,
  input  logic [INST_W-1:0] reqInst,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqClear,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rspData,
  output logic              rspTimeout,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata
);

  strobe_t stb;
  op_e     curOp;
  logic    curLegacy;
  logic    semGranted;
  op_e     opIn;

  assign opIn = op_e'(reqOp);

  steer_ctrl #(.POLL_LIMIT(POLL_LIMIT)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (opIn),
    .legacyIn  (legacyMode),
    .curOp     (curOp),
    .curLegacy (curLegacy),
    .busReady  (busReady),
    .semGranted(semGranted),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busy      (busy),
    .done      (done),
    .stb       (stb)
  );

  steer_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .GRP_W   (GRP_W),
    .INST_W  (INST_W),
    .GRP_LSB (GRP_LSB),
    .INST_LSB(INST_LSB),
    .MC_BIT  (MC_BIT),
    .SEL_ADDR(SEL_ADDR),
    .SEM_ADDR(SEM_ADDR)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqOp     (opIn),
    .legacyIn  (legacyMode),
    .reqAddr   (reqAddr),
    .reqGroup  (reqGroup),
    .reqInst   (reqInst),
    .reqWdata  (reqWdata),
    .reqClear  (reqClear),
    .busRdata  (busRdata),
    .curOp     (curOp),
    .curLegacy (curLegacy),
    .semGranted(semGranted),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .rspData   (rspData),
    .rspTimeout(rspTimeout)
  );

endmodule

// File: rtl/steer_seq_chk.sv
module steer_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEM_ADDR = 16'h0FD4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busReady
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busValid && !done));

  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busWrite) && $stable(busWdata)));

  p_release_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == SEM_ADDR) |-> (busWdata == DATA_W'(1)));

  p_done_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

bind steer_seq steer_seq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .SEM_ADDR(SEM_ADDR)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .busy    (busy),
  .done    (done),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busReady(busReady)
);

// File: tb/test_steer_seq.sv
module test_steer_seq;

  localparam logic [15:0] SEL = 16'h0FD0;
  localparam logic [15:0] SEM = 16'h0FD4;
  localparam int          PL  = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        legacyMode, reqValid;
  logic [1:0]  reqOp;
  logic [15:0] reqAddr;
  logic [3:0]  reqGroup, reqInst;
  logic [31:0] reqWdata, reqClear;
  logic        busy, done, rspTimeout, busValid, busWrite, busReady;
  logic [31:0] rspData, busWdata, busRdata;
  logic [15:0] busAddr;

  steer_seq i_steer_seq (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .reqValid(reqValid),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqGroup(reqGroup), .reqInst(reqInst),
    .reqWdata(reqWdata), .reqClear(reqClear), .busy(busy), .done(done),
    .rspData(rspData), .rspTimeout(rspTimeout), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata)
  );

  always #5 clk = ~clk;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  // bus responder model
  int          readyDelay = 0;
  int          waitCnt    = 0;
  int          semLeft    = 0;
  bit          semNever   = 0;
  logic [31:0] selModel   = 32'h0;
  logic [31:0] tgtMem [16];
  int          logN = 0;
  bit          logW [64];
  logic [15:0] logA [64];
  logic [31:0] logD [64];

  initial begin
    busReady = 1'b0;
    busRdata = 32'h0;
    forever begin
      @(negedge clk);
      busReady = 1'b0;
      if (rstN && busValid) begin
        if (waitCnt >= readyDelay) begin
          logic [31:0] d;
          waitCnt = 0;
          if (busWrite) begin
            d = busWdata;
            if (busAddr == SEL) selModel = busWdata;
            else if (busAddr != SEM) tgtMem[busAddr[3:0]] = busWdata;
          end else begin
            if (busAddr == SEL) d = selModel;
            else if (busAddr == SEM) begin
              if (semNever) d = 32'h0;
              else if (semLeft > 0) begin d = 32'h0; semLeft--; end
              else d = 32'h1;
            end else d = tgtMem[busAddr[3:0]];
            busRdata = d;
          end
          if (logN < 64) begin
            logW[logN] = busWrite; logA[logN] = busAddr; logD[logN] = d;
          end
          logN++;
          busReady = 1'b1;
        end else waitCnt++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkLog(int i, bit w, logic [15:0] a, logic [31:0] d, string req);
    logic [63:0] act, exp;
    exp = {15'd0, w, a, d};
    act = (i < logN) ? {15'd0, logW[i], logA[i], logD[i]} : 64'hDEAD;
    chk(act == exp, req, $sformatf("bus txn %0d", i), act, exp);
  endtask

  task automatic startReq(bit leg, logic [1:0] op, logic [15:0] a, logic [3:0] g,
                          logic [3:0] n, logic [31:0] wd, logic [31:0] cl);
    @(negedge clk);
    logN = 0;
    legacyMode = leg; reqOp = op; reqAddr = a; reqGroup = g; reqInst = n;
    reqWdata = wd; reqClear = cl; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // waits for done, checks rsp and the R11 pulse shape
  task automatic waitDone(logic [31:0] expData, bit expTmo, string req);
    int c = 0;
    while (!done && c < 2000) begin @(negedge clk); c++; end
    chk(done, req, "done seen", {63'd0, done}, 64'd1);
    chk(busy, "R11", "busy during done", {63'd0, busy}, 64'd1);
    chk(rspData == expData, req, "rspData", {32'd0, rspData}, {32'd0, expData});
    chk(rspTimeout == expTmo, req, "rspTimeout", {63'd0, rspTimeout}, {63'd0, expTmo});
    @(negedge clk);
    chk(!done && !busy, "R11", "done one cycle, busy falls", {62'd0, done, busy}, 64'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !busValid, "R1", "reset state", {61'd0, busy, done, busValid}, 64'd0);
  endtask

  task automatic t_new_read;
    readyDelay = 2; semLeft = 2; semNever = 0; tgtMem[1] = 32'hCAFE0001;
    startReq(0, 2'd0, 16'h0101, 4'd2, 4'd5, 32'h0, 32'h0);
    waitDone(32'hCAFE0001, 0, "R5");
    chk(logN == 6, "R3", "txn count new read", logN, 6);
    chkLog(0, 0, SEM, 32'h0, "R3");
    chkLog(1, 0, SEM, 32'h0, "R3");
    chkLog(2, 0, SEM, 32'h1, "R3");
    chkLog(3, 1, SEL, 32'h0001_0205, "R5");
    chkLog(4, 0, 16'h0101, 32'hCAFE0001, "R5");
    chkLog(5, 1, SEM, 32'h1, "R7");
  endtask

  task automatic t_new_write;
    readyDelay = 0; semLeft = 0;
    startReq(0, 2'd1, 16'h0102, 4'd1, 4'd3, 32'h1234_5678, 32'h0);
    waitDone(32'h0, 0, "R6");
    chk(logN == 5, "R6", "txn count new write", logN, 5);
    chkLog(0, 0, SEM, 32'h1, "R3");
    chkLog(1, 1, SEL, 32'h0000_0103, "R6");
    chkLog(2, 1, 16'h0102, 32'h1234_5678, "R6");
    chkLog(3, 1, SEL, 32'h0001_0000, "R6");
    chkLog(4, 1, SEM, 32'h1, "R7");
  endtask

  task automatic t_timeout;
    readyDelay = 0; semNever = 1; tgtMem[3] = 32'h0BAD_F00D;
    startReq(0, 2'd0, 16'h0103, 4'd0, 4'd0, 32'h0, 32'h0);
    waitDone(32'h0BAD_F00D, 1, "R4");
    chk(logN == PL + 3, "R4", "polls then steer", logN, PL + 3);
    chkLog(PL - 1, 0, SEM, 32'h0, "R4");
    chkLog(PL, 1, SEL, 32'h0001_0000, "R4");
    chkLog(PL + 2, 1, SEM, 32'h1, "R7");
    semNever = 0;
  endtask

  task automatic t_legacy_rw;
    readyDelay = 1; selModel = 32'h0001_36C9; tgtMem[4] = 32'h5555_AAAA;
    startReq(1, 2'd0, 16'h0104, 4'd4, 4'd2, 32'h0, 32'h0);
    waitDone(32'h5555_AAAA, 0, "R8");
    chk(logN == 4, "R8", "txn count legacy read", logN, 4);
    chkLog(0, 0, SEL, 32'h0001_36C9, "R8");
    chkLog(1, 1, SEL, 32'h0001_34C2, "R8");
    chkLog(2, 0, 16'h0104, 32'h5555_AAAA, "R8");
    chkLog(3, 1, SEL, 32'h0001_36C9, "R8");
    startReq(1, 2'd1, 16'h0104, 4'd4, 4'd2, 32'h7777_0000, 32'h0);
    waitDone(32'h0, 0, "R8");
    chkLog(1, 1, SEL, 32'h0000_34C2, "R8");
    chkLog(2, 1, 16'h0104, 32'h7777_0000, "R8");
    chkLog(3, 1, SEL, 32'h0001_36C9, "R8");
    chk(selModel == 32'h0001_36C9, "R8", "selector restored", selModel, 32'h0001_36C9);
    begin
      bit semSeen = 0;
      for (int i = 0; i < logN; i++) if (logA[i] == SEM) semSeen = 1;
      chk(!semSeen, "R7", "legacy skips semaphore", {63'd0, semSeen}, 64'd0);
    end
  endtask

  task automatic t_mcast;
    readyDelay = 0;
    startReq(0, 2'd2, 16'h0105, 4'd9, 4'd9, 32'hA5A5_0001, 32'h0);
    waitDone(32'h0, 0, "R9");
    chk(logN == 4, "R9", "txn count new mcast", logN, 4);
    chkLog(1, 1, SEL, 32'h0001_0000, "R9");
    chkLog(2, 1, 16'h0105, 32'hA5A5_0001, "R9");
    chkLog(3, 1, SEM, 32'h1, "R7");
    startReq(1, 2'd2, 16'h0106, 4'd9, 4'd9, 32'hA5A5_0002, 32'h0);
    waitDone(32'h0, 0, "R9");
    chk(logN == 1, "R9", "txn count legacy mcast", logN, 1);
    chkLog(0, 1, 16'h0106, 32'hA5A5_0002, "R9");
  endtask

  task automatic t_rmw;
    readyDelay = 0; tgtMem[7] = 32'hFFFF_0000;
    startReq(0, 2'd3, 16'h0107, 4'd3, 4'd1, 32'h0000_00AB, 32'h00FF_0000);
    waitDone(32'hFFFF_0000, 0, "R10");
    chk(logN == 6, "R10", "txn count new rmw", logN, 6);
    chkLog(1, 1, SEL, 32'h0001_0301, "R10");
    chkLog(2, 0, 16'h0107, 32'hFFFF_0000, "R10");
    chkLog(3, 1, SEL, 32'h0001_0000, "R10");
    chkLog(4, 1, 16'h0107, 32'hFF00_00AB, "R10");
    chkLog(5, 1, SEM, 32'h1, "R7");
    selModel = 32'h0000_0000; tgtMem[8] = 32'h0000_00F0;
    startReq(1, 2'd3, 16'h0108, 4'd1, 4'd1, 32'h0000_0001, 32'h0000_0030);
    waitDone(32'h0000_00F0, 0, "R10");
    chk(logN == 5, "R10", "txn count legacy rmw", logN, 5);
    chkLog(1, 1, SEL, 32'h0000_0101, "R10");
    chkLog(3, 1, SEL, 32'h0000_0000, "R10");
    chkLog(4, 1, 16'h0108, 32'h0000_00C1, "R10");
  endtask

  task automatic t_ignore_busy;
    readyDelay = 3; tgtMem[9] = 32'h0000_0009; tgtMem[10] = 32'h0000_000A;
    startReq(0, 2'd0, 16'h0109, 4'd0, 4'd1, 32'h0, 32'h0);
    reqOp = 2'd1; reqAddr = 16'h010A; reqWdata = 32'hFFFF_FFFF; reqValid = 1'b1;
    repeat (2) @(negedge clk);
    reqValid = 1'b0;
    waitDone(32'h0000_0009, 0, "R1");
    repeat (4) @(negedge clk);
    chk(logN == 4, "R1", "no extra traffic", logN, 4);
    chk(tgtMem[10] == 32'h0000_000A, "R1", "ignored write", tgtMem[10], 32'h0000_000A);
    chk(!busy, "R1", "no second sequence", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; legacyMode = 1'b0; reqOp = 2'd0;
    reqAddr = '0; reqGroup = '0; reqInst = '0; reqWdata = '0; reqClear = '0;
    for (int i = 0; i < 16; i++) tgtMem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_new_read();
    t_new_write();
    t_timeout();
    t_legacy_rw();
    t_mcast();
    t_rmw();
    t_ignore_busy();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule